// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block is a small first-in first-out store placed between a receive byte source and a host-facing register decoder. Bytes arriving from the line side are taken only while the receiver is enabled and the queue has room. The host sees the oldest stored byte on `rd_data` and removes it by pulsing `pop`. Two status levels report whether any byte is waiting and whether the queue is full.

A line-break event is handled differently from an ordinary byte. It always inserts a zero byte, even when the queue is full. In that case the zero takes the place of the most recently stored byte and the occupancy does not change. A break also sets a sticky delta-break flag, which stays set until the command decoder clears it. A flush input from the receiver reset command empties the queue in one cycle.

Top module: `rx_hold_queue`

## Requirements
- R1: Bytes leave in arrival order. While `rx_ready` is 1, `rd_data` shows the oldest stored byte, and a `pop` exposes the next one from the following cycle on. Storage wraps around for any number of bytes.
- R2: While the queue is empty, `rd_data` is 0. A `pop` in that state changes no flag and no stored state.
- R3: A `pop` on a full queue clears `full` in the next cycle. A `pop` that removes the last byte clears `rx_ready`.
- R4: An accepted byte sets `rx_ready`. `full` goes to 1 when the count reaches DEPTH (4 by default).
- R5: `in_ready` equals `rx_en` AND NOT `full`. An `in_valid` byte offered while `in_ready` is 0 is discarded.
- R6: `brk_evt` stores a zero byte and sets `brk_flag` whatever the fill level. On a full queue with no `pop` in the same cycle, the zero replaces the newest entry and `full` stays 1.
- R7: `flush` empties the queue by the next cycle, clearing `rx_ready` and `full`. It overrides any `pop`, byte or break in the same cycle, but a break still sets `brk_flag`.
- R8: A `pop` and an accepted byte in the same cycle are both carried out, so the occupancy is unchanged.
- R9: When `brk_evt` and `in_valid` occur in the same cycle, only the zero byte is stored and the offered byte is dropped.
- R10: `brk_flag` stays 1 until `brk_clr` is pulsed. A `brk_evt` in the same cycle as `brk_clr` leaves the flag at 1.
- R11: After reset the queue is empty, `rx_ready`, `full` and `brk_flag` are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| rx_en | input | 1 | Receiver enable level from the command decoder |
| in_valid | input | 1 | A line-side byte is offered this cycle |
| in_data | input | WIDTH | Offered byte |
| in_ready | output | 1 | Queue will take an offered byte this cycle |
| brk_evt | input | 1 | Line-break event pulse |
| brk_clr | input | 1 | Clears the delta-break flag |
| pop | input | 1 | Host read of the data register; removes the head byte |
| rd_data | output | WIDTH | Head byte, or zero when empty |
| flush | input | 1 | Receiver reset: empties the queue |
| rx_ready | output | 1 | At least one byte is stored |
| full | output | 1 | DEPTH bytes are stored |
| brk_flag | output | 1 | Sticky delta-break flag |

## Verification
The bench builds the block with its defaults, DEPTH of 4 and WIDTH of 8. At that size the queue fills after four bytes, so the full boundary, the break overwrite of the newest entry and a break combined with a pop on a full queue can each be reached in a few cycles. The vector sequence stores more than eleven bytes in total, which wraps both pointers several times. Along the way it checks that overwritten and dropped bytes never appear at `rd_data`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Per-cycle decision produced by the arbiter and consumed by the
  // pointer and storage logic.
  typedef struct packed {
    logic flush;      // empty the queue
    logic push;       // write one entry
    logic overwrite;  // push lands on the newest entry, no pointer move
    logic zero_fill;  // push data is forced to zero (break)
    logic pop;        // retire the head entry
  } rxq_op_t;

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rxq_arbiter.sv
module rxq_arbiter
  import rxq_pkg::*;
(
  input  logic    rx_en,
  input  logic    in_valid,
  input  logic    brk_evt,
  input  logic    pop_req,
  input  logic    flush_req,
  input  logic    is_empty,
  input  logic    is_full,
  output logic    in_ready,
  output rxq_op_t op
);

  logic pop_ok;

  assign in_ready = rx_en & ~is_full;
  assign pop_ok   = pop_req & ~is_empty;

  always_comb begin
    op = '0;
    if (flush_req) begin
      op.flush = 1'b1;
    end else begin
      op.pop = pop_ok;
      if (brk_evt) begin
        // break bypasses the room check; with no room and no pop it
        // reuses the newest slot
        op.push      = 1'b1;
        op.zero_fill = 1'b1;
        op.overwrite = is_full & ~pop_ok;
      end else begin
        op.push = in_valid & in_ready;
      end
    end
  end

endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rxq_op_t       op,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          is_empty,
  output logic          is_full
);

  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [AW-1:0] wr_q, wr_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv_wr;

  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - AW'(1);
  endfunction

  assign adv_wr = op.push & ~op.overwrite;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (op.flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (adv_wr) wr_d = step_up(wr_q);
      if (op.pop) rd_d = step_up(rd_q);
      case ({adv_wr, op.pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_addr  = op.overwrite ? step_down(wr_q) : wr_q;
  assign rd_addr  = rd_q;
  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == LIMIT);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en & (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_en) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_addr];

endmodule

// File: rtl/rxq_brk_flag.sv
module rxq_brk_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q, flag_d;

  // set wins over a same-cycle clear
  assign flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             brk_evt,
  input  logic             brk_clr,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  input  logic             flush,
  output logic             rx_ready,
  output logic             full,
  output logic             brk_flag
);

  localparam int AW = $clog2(DEPTH);

  logic             rst_sync_n;
  rxq_op_t          op;
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    rd_addr;
  logic             is_empty;
  logic             is_full;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] head;

  rxq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxq_arbiter u_arb (
    .rx_en     (rx_en),
    .in_valid  (in_valid),
    .brk_evt   (brk_evt),
    .pop_req   (pop),
    .flush_req (flush),
    .is_empty  (is_empty),
    .is_full   (is_full),
    .in_ready  (in_ready),
    .op        (op)
  );

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (op),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .is_empty (is_empty),
    .is_full  (is_full)
  );

  assign wr_data = op.zero_fill ? '0 : in_data;

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (op.push),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (head)
  );

  rxq_brk_flag u_brk (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (brk_evt),
    .clr   (brk_clr),
    .flag  (brk_flag)
  );

  assign rd_data  = is_empty ? '0 : head;
  assign rx_ready = ~is_empty;
  assign full     = is_full;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             brk_evt,
  input logic             brk_clr,
  input logic             pop,
  input logic             flush,
  input logic [WIDTH-1:0] rd_data,
  input logic             rx_ready,
  input logic             full,
  input logic             brk_flag
);

  // R4
  full_has_data_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full |-> rx_ready);

  // R5
  full_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full |-> !in_ready);

  // R2
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_ready |-> (rd_data == '0));

  // R2
  empty_pop_inert_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rx_ready && !in_valid && !brk_evt && !flush) |=> !rx_ready);

  // R3
  pop_frees_room_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop && full && !brk_evt && !flush) |=> !full);

  // R6
  brk_overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (full && brk_evt && !pop && !flush) |=> full);

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (!rx_ready && !full));

  // R8
  pop_push_balance_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop && rx_ready && in_valid && in_ready && !brk_evt && !flush) |=> (rx_ready && !full));

  // R10
  brk_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_evt |=> brk_flag);

  // R10
  brk_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_clr && !brk_evt) |=> !brk_flag);

  // R10
  brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_flag && !brk_clr) |=> brk_flag);

endmodule

bind rx_hold_queue rxq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .brk_evt    (brk_evt),
  .brk_clr    (brk_clr),
  .pop        (pop),
  .flush      (flush),
  .rd_data    (rd_data),
  .rx_ready   (rx_ready),
  .full       (full),
  .brk_flag   (brk_flag)
);

// File: tb/rx_hold_queue_tb_top.sv
module rx_hold_queue_tb_top;

  localparam int WIDTH = 8;
  localparam int NVEC  = 23;
  localparam time TCLK = 8ns;

  logic             clk;
  logic             rst_n;
  logic             rx_en, in_valid, brk_evt, brk_clr, pop, flush;
  logic [WIDTH-1:0] in_data;
  logic             in_ready, rx_ready, full, brk_flag;
  logic [WIDTH-1:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  rx_hold_queue #(.DEPTH(4), .WIDTH(WIDTH)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .brk_evt  (brk_evt),
    .brk_clr  (brk_clr),
    .pop      (pop),
    .rd_data  (rd_data),
    .flush    (flush),
    .rx_ready (rx_ready),
    .full     (full),
    .brk_flag (brk_flag)
  );

  initial clk = 1'b0;
  always #(TCLK / 2) clk = ~clk;

  // row: req(4) | en vld brk pop flush clr (6) | data(8) |
  //      exp rdy full brk inrdy (4) | exp rd_data(8)
  localparam logic [29:0] VEC [NVEC] = '{
    {4'd4,  6'b110000, 8'h11, 4'b1001, 8'h11},  // R4 first byte
    {4'd1,  6'b110000, 8'h22, 4'b1001, 8'h11},  // R1 head stays oldest
    {4'd1,  6'b110000, 8'h33, 4'b1001, 8'h11},  // R1
    {4'd4,  6'b110000, 8'h44, 4'b1100, 8'h11},  // R4 reaches full
    {4'd5,  6'b110000, 8'h55, 4'b1100, 8'h11},  // R5 dropped while full
    {4'd3,  6'b100100, 8'h00, 4'b1001, 8'h22},  // R3 pop clears full
    {4'd8,  6'b110100, 8'h66, 4'b1001, 8'h33},  // R8 pop and push together
    {4'd4,  6'b110000, 8'h77, 4'b1100, 8'h33},  // R4 full again
    {4'd6,  6'b111000, 8'h88, 4'b1110, 8'h33},  // R6 break overwrites 77
    {4'd10, 6'b100001, 8'h00, 4'b1100, 8'h33},  // R10 clear flag
    {4'd1,  6'b100100, 8'h00, 4'b1001, 8'h44},  // R1
    {4'd6,  6'b100100, 8'h00, 4'b1001, 8'h66},  // R6 next is zero, not 77
    {4'd9,  6'b111000, 8'h99, 4'b1011, 8'h66},  // R9 break beats byte
    {4'd6,  6'b100100, 8'h00, 4'b1011, 8'h00},  // R6 zero from overwrite
    {4'd9,  6'b100100, 8'h00, 4'b1011, 8'h00},  // R9 zero, 99 absent
    {4'd3,  6'b100100, 8'h00, 4'b0011, 8'h00},  // R3 last pop empties
    {4'd2,  6'b100100, 8'h00, 4'b0011, 8'h00},  // R2 pop while empty
    {4'd5,  6'b010000, 8'hAA, 4'b0010, 8'h00},  // R5 receiver disabled
    {4'd4,  6'b110000, 8'hBB, 4'b1011, 8'hBB},  // R4 wrapped pointers
    {4'd7,  6'b110110, 8'hCC, 4'b0011, 8'h00},  // R7 flush wins
    {4'd10, 6'b101001, 8'h00, 4'b1011, 8'h00},  // R10 break beats clear
    {4'd10, 6'b100001, 8'h00, 4'b1001, 8'h00},  // R10 clear
    {4'd7,  6'b100010, 8'h00, 4'b0001, 8'h00}   // R7 flush
  };

  task automatic check(input string req, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic vld, input logic brk,
                       input logic pp, input logic fl, input logic clr,
                       input logic [WIDTH-1:0] d);
    rx_en = en; in_valid = vld; brk_evt = brk; pop = pp; flush = fl;
    brk_clr = clr; in_data = d;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0; brk_evt = 1'b0; pop = 1'b0; flush = 1'b0; brk_clr = 1'b0;
  endtask

  initial begin
    #(TCLK * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rx_en = 1'b0; in_data = '0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11", "rx_ready", {7'd0, rx_ready}, 8'd0);
    check("R11", "full",     {7'd0, full},     8'd0);
    check("R11", "brk_flag", {7'd0, brk_flag}, 8'd0);
    check("R11", "rd_data",  rd_data,          8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [29:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d row%0d", v[29:26], i);
      drive(v[25], v[24], v[23], v[22], v[21], v[20], v[19:12]);
      check(tag, "rx_ready", {7'd0, rx_ready}, {7'd0, v[11]});
      check(tag, "full",     {7'd0, full},     {7'd0, v[10]});
      check(tag, "brk_flag", {7'd0, brk_flag}, {7'd0, v[9]});
      check(tag, "in_ready", {7'd0, in_ready}, {7'd0, v[8]});
      check(tag, "rd_data",  rd_data,          v[7:0]);
    end

    // R6 break with pop on a full queue: both happen, stays full
    for (int k = 1; k <= 4; k++) drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'(k));
    check("R4", "full after fill", {7'd0, full}, 8'd1);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R6", "full after brk+pop", {7'd0, full}, 8'd1);
    check("R6", "head after brk+pop", rd_data, 8'h02);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R1", "head", rd_data, 8'h03);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R1", "head", rd_data, 8'h04);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R6", "break zero at tail", rd_data, 8'h00);
    check("R6", "rx_ready", {7'd0, rx_ready}, 8'd1);

    // R11 reset mid-operation
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A);
    idle();
    rst_n = 1'b0;
    #1;
    check("R11", "rx_ready in reset", {7'd0, rx_ready}, 8'd0);
    check("R11", "brk_flag in reset", {7'd0, brk_flag}, 8'd0);
    check("R11", "rd_data in reset",  rd_data,          8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "rx_ready after reset", {7'd0, rx_ready}, 8'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule